// File: doc/BRIEF.md
# Power-State-Aware Clock Output Controller

This block decides two things for a power-management subsystem: whether the low-frequency reference oscillator is kept running, and whether the clock output pin is driven. Both decisions depend on the current power state and on a small set of configuration bits. The power sequencer supplies the current state, plus a flag and target state for any transition in progress, and a 3-bit timeslot counter that steps through that transition. A clock verifier reports whether each candidate source is valid.

The output enable has three ways to change. It follows programmed timeslots while the chip moves into ON or into SLEEP. Software can also write it directly, but only in ON or SLEEP. In OFF it is forced low. When the inhibit option is set, the block holds the sequencer's move into ON until the selected clock source has been verified. The pin stage either drives the selected clock push-pull, or drives it open-drain by enabling the pin only while the clock is low.

The oscillator enable bit comes from a non-volatile configuration input. It is captured once, just after reset is released. All other configuration fields are loaded through a plain write port.

Top module: `clkout_ctrl`

## Requirements
- R1: Power state encoding is OFF=0, ON=1, SLEEP=2, BACKUP=3. In OFF, ON and SLEEP, `osc_en` equals the stored oscillator enable bit.
- R2: In BACKUP, `osc_en` is 1 only when both the stored oscillator enable bit and the backup-run bit are 1.
- R3: The stored oscillator enable bit takes the value of `nv_osc_en` at the first rising edge after `rst` is released. It is not changed afterwards: not by later changes of `nv_osc_en`, and not by writes through `wr_osc_en`.
- R4: Source select bit 0 picks `clk_osc` and 1 picks `clk_fll`. With the output enabled in push-pull mode, `pin_out` follows the selected clock and `pin_oe` is 1.
- R5: When `pwr_state` is OFF and no transition is active, the output enable is 0 from the next edge on, so `pin_oe` and `pin_out` are 0.
- R6: A write with `wr_en` sets the output enable to `wr_out_en` at the next edge only when `pwr_state` is ON or SLEEP. In other states the write leaves the output enable unchanged.
- R7: During a transition to ON (`trans_active`=1, `trans_target`=1), the output becomes enabled at the edge where `trans_slot` equals the programmed on-slot. During a transition to SLEEP (`trans_target`=2), it becomes disabled at the edge where `trans_slot` equals the programmed sleep-slot.
- R8: A programmed slot value of 0 means the transition does not change the output enable.
- R9: While inhibit is 1 and the selected source's valid input (`osc_valid` or `fll_valid`, chosen by the source select bit) is 0, the output is not enabled, neither by a slot match nor by a write. In that condition `trans_hold` is 1 during a transition to ON. Otherwise `trans_hold` is 0.
- R10: With the open-drain bit set, `pin_out` is 0 and `pin_oe` is 1 only while the output is enabled and the selected clock is 0. `drive_od` equals the open-drain bit.
- R11: While `rst` is high and after it, all configuration bits and the output enable are 0 until loaded, so `osc_en`, `pin_oe`, `pin_out`, `drive_od` and `trans_hold` read 0 during reset.
- R12: When a slot action and a write to the output enable occur at the same edge, the slot action wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_osc_en | input | 1 | Non-volatile oscillator enable value |
| pwr_state | input | 2 | Current power state (0 OFF, 1 ON, 2 SLEEP, 3 BACKUP) |
| trans_active | input | 1 | A power state transition is in progress |
| trans_target | input | 2 | Target state of the transition |
| trans_slot | input | 3 | Transition timeslot counter |
| osc_valid | input | 1 | Verifier: oscillator source valid |
| fll_valid | input | 1 | Verifier: loop source valid |
| clk_osc | input | 1 | Oscillator clock signal |
| clk_fll | input | 1 | Loop-generated clock signal |
| wr_en | input | 1 | Configuration write strobe |
| wr_osc_en | input | 1 | Write data for oscillator enable (ignored) |
| wr_bkup_en | input | 1 | Write data: keep oscillator running in BACKUP |
| wr_out_en | input | 1 | Write data: output enable |
| wr_src_fll | input | 1 | Write data: source select (1 = loop clock) |
| wr_inhibit | input | 1 | Write data: hold ON until source verified |
| wr_open_drain | input | 1 | Write data: open-drain drive mode |
| wr_on_slot | input | 3 | Write data: enable slot for transitions to ON |
| wr_slp_slot | input | 3 | Write data: disable slot for transitions to SLEEP |
| osc_en | output | 1 | Oscillator run enable |
| pin_out | output | 1 | Clock pin data |
| pin_oe | output | 1 | Clock pin output enable |
| drive_od | output | 1 | Pin drive mode (1 = open-drain) |
| trans_hold | output | 1 | Hold request to the power sequencer |

## Verification
A wrong output-enable state shows at `pin_oe` one edge after the slot match, write or OFF entry that should have set it, because the pins follow that register combinationally. A wrong stored oscillator bit shows immediately at `osc_en` in every state, and a wrong backup bit shows as soon as the state is BACKUP. A wrong source or inhibit decision shows in the same cycle at `trans_hold` and at `pin_out`.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    localparam int SLOT_W = 3;

    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_ON     = 2'd1,
        PS_SLEEP  = 2'd2,
        PS_BACKUP = 2'd3
    } pstate_e;

    typedef struct packed {
        logic              osc_en;
        logic              bkup_en;
        logic              src_fll;
        logic              inhibit;
        logic              open_drain;
        logic [SLOT_W-1:0] on_slot;
        logic [SLOT_W-1:0] slp_slot;
    } cfg_t;

    // A zero slot never matches: the transition leaves the output alone.
    function automatic logic slot_hit(logic [SLOT_W-1:0] cnt, logic [SLOT_W-1:0] prog);
        return (prog != '0) && (cnt == prog);
    endfunction

    function automatic logic osc_should_run(pstate_e st, logic en, logic bkup);
        return en && ((st != PS_BACKUP) || bkup);
    endfunction

endpackage

// File: rtl/clkout_cfg_regs.sv
module clkout_cfg_regs
    import clkout_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nv_osc_en,
    input  logic wr_en,
    input  cfg_t wr_cfg,
    output cfg_t cfg
);
    cfg_t cfg_q;
    logic loaded_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '0;
            loaded_q <= 1'b0;
        end else begin
            if (!loaded_q) begin
                cfg_q.osc_en <= nv_osc_en;
                loaded_q     <= 1'b1;
            end
            if (wr_en) begin
                cfg_q.bkup_en    <= wr_cfg.bkup_en;
                cfg_q.src_fll    <= wr_cfg.src_fll;
                cfg_q.inhibit    <= wr_cfg.inhibit;
                cfg_q.open_drain <= wr_cfg.open_drain;
                cfg_q.on_slot    <= wr_cfg.on_slot;
                cfg_q.slp_slot   <= wr_cfg.slp_slot;
            end
        end
    end

    assign cfg = cfg_q;

    // R3: once loaded, the oscillator bit never moves
    a_r3_osc_locked: assert property (@(posedge clk) disable iff (rst)
        $past(loaded_q) |-> $stable(cfg_q.osc_en));

    // R3: a write carrying a different oscillator value is not taken
    a_r3_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && loaded_q && (wr_cfg.osc_en != cfg_q.osc_en)) |=>
        (cfg_q.osc_en != $past(wr_cfg.osc_en)));

endmodule

// File: rtl/clkout_gate_ctrl.sv
module clkout_gate_ctrl
    import clkout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pstate_e           pwr_state,
    input  logic              trans_active,
    input  logic [1:0]        trans_target,
    input  logic [SLOT_W-1:0] trans_slot,
    input  logic              inhibit,
    input  logic [SLOT_W-1:0] on_slot,
    input  logic [SLOT_W-1:0] slp_slot,
    input  logic              src_ok,
    input  logic              wr_en,
    input  logic              wr_out_en,
    output logic              out_en,
    output logic              trans_hold
);
    logic en_q, en_d;
    logic into_on, into_slp, may_enable, write_window;

    assign into_on      = trans_active && (trans_target == PS_ON);
    assign into_slp     = trans_active && (trans_target == PS_SLEEP);
    assign may_enable   = !inhibit || src_ok;
    assign write_window = (pwr_state == PS_ON) || (pwr_state == PS_SLEEP);

    always_comb begin
        en_d = en_q;
        if (pwr_state == PS_OFF && !trans_active) begin
            en_d = 1'b0;
        end else if (into_on && slot_hit(trans_slot, on_slot) && may_enable) begin
            en_d = 1'b1;
        end else if (into_slp && slot_hit(trans_slot, slp_slot)) begin
            en_d = 1'b0;
        end else if (wr_en && write_window) begin
            if (!wr_out_en) begin
                en_d = 1'b0;
            end else if (may_enable) begin
                en_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en_d;
    end

    assign out_en     = en_q;
    assign trans_hold = into_on && inhibit && !src_ok;

    // R5: OFF without a transition clears the output
    a_r5_off_clears: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == PS_OFF && !trans_active) |=> !en_q);

    // R9: no enable unless the source was verified or inhibit was clear
    a_r9_verified_first: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(!inhibit || src_ok));

    // R6: an enable outside a transition needs ON or SLEEP
    a_r6_write_window: assert property (@(posedge clk) disable iff (rst)
        ($rose(en_q) && !$past(trans_active)) |->
        $past(pwr_state == PS_ON || pwr_state == PS_SLEEP));

endmodule

// File: rtl/clkout_pin_drive.sv
module clkout_pin_drive (
    input  logic out_en,
    input  logic open_drain,
    input  logic src_fll,
    input  logic clk_osc,
    input  logic clk_fll,
    output logic pin_out,
    output logic pin_oe
);
    logic sel_clk;

    assign sel_clk = src_fll ? clk_fll : clk_osc;

    always_comb begin
        if (!out_en) begin
            pin_out = 1'b0;
            pin_oe  = 1'b0;
        end else if (open_drain) begin
            pin_out = 1'b0;
            pin_oe  = !sel_clk;
        end else begin
            pin_out = sel_clk;
            pin_oe  = 1'b1;
        end
    end

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkout_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              nv_osc_en,
    input  logic [1:0]        pwr_state,
    input  logic              trans_active,
    input  logic [1:0]        trans_target,
    input  logic [SLOT_W-1:0] trans_slot,
    input  logic              osc_valid,
    input  logic              fll_valid,
    input  logic              clk_osc,
    input  logic              clk_fll,
    input  logic              wr_en,
    input  logic              wr_osc_en,
    input  logic              wr_bkup_en,
    input  logic              wr_out_en,
    input  logic              wr_src_fll,
    input  logic              wr_inhibit,
    input  logic              wr_open_drain,
    input  logic [SLOT_W-1:0] wr_on_slot,
    input  logic [SLOT_W-1:0] wr_slp_slot,
    output logic              osc_en,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              drive_od,
    output logic              trans_hold
);
    pstate_e st;
    cfg_t    wr_cfg, cfg;
    logic    src_ok, out_en;

    assign st = pstate_e'(pwr_state);

    always_comb begin
        wr_cfg            = '0;
        wr_cfg.osc_en     = wr_osc_en;
        wr_cfg.bkup_en    = wr_bkup_en;
        wr_cfg.src_fll    = wr_src_fll;
        wr_cfg.inhibit    = wr_inhibit;
        wr_cfg.open_drain = wr_open_drain;
        wr_cfg.on_slot    = wr_on_slot;
        wr_cfg.slp_slot   = wr_slp_slot;
    end

    clkout_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .nv_osc_en (nv_osc_en),
        .wr_en     (wr_en),
        .wr_cfg    (wr_cfg),
        .cfg       (cfg)
    );

    assign src_ok = cfg.src_fll ? fll_valid : osc_valid;

    clkout_gate_ctrl u_gate (
        .clk          (clk),
        .rst          (rst),
        .pwr_state    (st),
        .trans_active (trans_active),
        .trans_target (trans_target),
        .trans_slot   (trans_slot),
        .inhibit      (cfg.inhibit),
        .on_slot      (cfg.on_slot),
        .slp_slot     (cfg.slp_slot),
        .src_ok       (src_ok),
        .wr_en        (wr_en),
        .wr_out_en    (wr_out_en),
        .out_en       (out_en),
        .trans_hold   (trans_hold)
    );

    clkout_pin_drive u_pin (
        .out_en     (out_en),
        .open_drain (cfg.open_drain),
        .src_fll    (cfg.src_fll),
        .clk_osc    (clk_osc),
        .clk_fll    (clk_fll),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    assign osc_en   = osc_should_run(st, cfg.osc_en, cfg.bkup_en);
    assign drive_od = cfg.open_drain;

    // R10: an open-drain pin never drives high
    a_r10_od_low: assert property (@(posedge clk) disable iff (rst)
        (drive_od && pin_oe) |-> !pin_out);

    // R2: BACKUP without the backup bit stops the oscillator
    a_r2_backup_stop: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 2'd3 && $past(wr_en && !wr_bkup_en) && !$past(rst)) |-> !osc_en);

endmodule

// File: tb/clkout_ctrl_test.sv
module clkout_ctrl_test;
    localparam int PERIOD = 10;

    logic clk = 0, rst = 1, nv = 0;
    logic [1:0] pst = 0, ttgt = 0;
    logic tact = 0;
    logic [2:0] tslot = 0;
    logic vosc = 0, vfll = 0, co = 0, cf = 0;
    logic wr_en = 0, wr_osc = 0, wr_bk = 0, wr_out = 0, wr_fll = 0, wr_inh = 0, wr_od = 0;
    logic [2:0] wr_on = 0, wr_slp = 0;
    logic osc_en, pin_out, pin_oe, drive_od, trans_hold;

    // bench model state
    logic exp_en = 0, m_osc = 0, m_loaded = 0, m_bk = 0, m_fll = 0, m_inh = 0, m_od = 0;
    logic [2:0] m_on = 0, m_slp = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    clkout_ctrl uut (
        .clk(clk), .rst(rst), .nv_osc_en(nv), .pwr_state(pst), .trans_active(tact),
        .trans_target(ttgt), .trans_slot(tslot), .osc_valid(vosc), .fll_valid(vfll),
        .clk_osc(co), .clk_fll(cf), .wr_en(wr_en), .wr_osc_en(wr_osc),
        .wr_bkup_en(wr_bk), .wr_out_en(wr_out), .wr_src_fll(wr_fll),
        .wr_inhibit(wr_inh), .wr_open_drain(wr_od), .wr_on_slot(wr_on),
        .wr_slp_slot(wr_slp), .osc_en(osc_en), .pin_out(pin_out), .pin_oe(pin_oe),
        .drive_od(drive_od), .trans_hold(trans_hold)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        logic nxt, ok;
        ok  = !m_inh || (m_fll ? vfll : vosc);
        nxt = exp_en;
        if (rst) nxt = 0;
        else if (pst == 0 && !tact) nxt = 0;
        else if (tact && ttgt == 1 && m_on != 0 && tslot == m_on && ok) nxt = 1;
        else if (tact && ttgt == 2 && m_slp != 0 && tslot == m_slp) nxt = 0;
        else if (wr_en && (pst == 1 || pst == 2)) begin
            if (!wr_out) nxt = 0;
            else if (ok) nxt = 1;
        end
        @(posedge clk);
        exp_en = nxt;
        if (rst) begin
            {m_osc, m_loaded, m_bk, m_fll, m_inh, m_od} = '0;
            m_on = 0; m_slp = 0;
        end else begin
            if (!m_loaded) begin m_osc = nv; m_loaded = 1; end
            if (wr_en) begin
                m_bk = wr_bk; m_fll = wr_fll; m_inh = wr_inh; m_od = wr_od;
                m_on = wr_on; m_slp = wr_slp;
            end
        end
        @(negedge clk); #1;
    endtask

    task automatic chk_pins(string req);
        logic sel;
        #1;
        sel = m_fll ? cf : co;
        chk(req, "pin_oe", pin_oe, exp_en && (m_od ? !sel : 1'b1));
        chk(req, "pin_out", pin_out, exp_en && !m_od && sel);
        chk(req, "drive_od", drive_od, m_od);
    endtask

    task automatic chk_osc(string req);
        #1;
        chk(req, "osc_en", osc_en, m_osc && (pst != 3 || m_bk));
    endtask

    task automatic chk_hold(string req);
        #1;
        chk(req, "trans_hold", trans_hold,
            tact && ttgt == 1 && m_inh && !(m_fll ? vfll : vosc));
    endtask

    task automatic prog(logic bk, logic out, logic fll, logic inh, logic od,
                        logic [2:0] on, logic [2:0] slp);
        wr_bk = bk; wr_out = out; wr_fll = fll; wr_inh = inh; wr_od = od;
        wr_on = on; wr_slp = slp; wr_en = 1;
        tick();
        wr_en = 0;
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        if (!finished) $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R11, R3, R1, R2: reset, load once, oscillator decision per state
        for (int n = 0; n < 2; n++) begin
            rst = 1; nv = n[0]; pst = 0;
            tick(); tick();
            chk_pins("R11"); chk_osc("R11"); chk_hold("R11");
            rst = 0;
            tick(); chk_osc("R3");
            nv = ~nv; tick(); chk_osc("R3");
            wr_osc = ~m_osc; prog(0, 0, 0, 0, 0, 0, 0); chk_osc("R3");
            for (int s = 0; s < 4; s++)
                for (int b = 0; b < 2; b++) begin
                    prog(b[0], 0, 0, 0, 0, 0, 0);
                    pst = s[1:0];
                    chk_osc(s == 3 ? "R2" : "R1");
                end
        end
        // R6: write window
        pst = 0; prog(0, 1, 0, 0, 0, 0, 0); chk_pins("R6");
        pst = 3; prog(0, 1, 0, 0, 0, 0, 0); chk_pins("R6");
        pst = 1; prog(0, 1, 0, 0, 0, 0, 0); co = 1; chk_pins("R6");
        pst = 2; prog(0, 0, 0, 0, 0, 0, 0); chk_pins("R6");
        pst = 1; prog(0, 1, 0, 0, 0, 0, 0); chk_pins("R6");
        // R4 and R10: source select and drive mode
        for (int od = 0; od < 2; od++)
            for (int f = 0; f < 2; f++) begin
                prog(0, 1, f[0], 0, od[0], 0, 0);
                for (int c = 0; c < 4; c++) begin
                    co = c[0]; cf = c[1];
                    chk_pins(od ? "R10" : "R4");
                end
            end
        prog(0, 1, 0, 0, 0, 0, 0);
        // R5: OFF forces off
        pst = 0; tick(); chk_pins("R5");
        // R7: slot sequencing into ON, then into SLEEP
        prog(0, 0, 0, 0, 0, 3, 5);
        tact = 1; ttgt = 1;
        for (int s = 1; s < 8; s++) begin tslot = s[2:0]; tick(); chk_pins("R7"); end
        pst = 1; ttgt = 2;
        for (int s = 1; s < 8; s++) begin tslot = s[2:0]; tick(); chk_pins("R7"); end
        // R8: zero slots change nothing
        tact = 0; prog(0, 1, 0, 0, 0, 0, 0); chk_pins("R8");
        tact = 1; ttgt = 2;
        for (int s = 0; s < 8; s++) begin tslot = s[2:0]; tick(); chk_pins("R8"); end
        tact = 0; pst = 0; tick(); tact = 1; ttgt = 1;
        for (int s = 0; s < 8; s++) begin tslot = s[2:0]; tick(); chk_pins("R8"); end
        // R9: inhibit until selected source valid
        tact = 0; pst = 1; vosc = 1; vfll = 0;
        prog(0, 0, 1, 1, 0, 2, 0);
        prog(0, 1, 1, 1, 0, 2, 0); chk_pins("R9");
        pst = 0; tact = 1; ttgt = 1;
        for (int s = 1; s < 8; s++) begin
            tslot = s[2:0]; chk_hold("R9"); tick(); chk_pins("R9");
        end
        vfll = 1; chk_hold("R9");
        tslot = 2; tick(); chk_pins("R9");
        // R12: slot action beats same-cycle write
        pst = 1; tact = 0; prog(0, 1, 1, 1, 0, 2, 4);
        tact = 1; ttgt = 2; tslot = 4;
        wr_bk = 0; wr_out = 1; wr_fll = 1; wr_inh = 1; wr_od = 0; wr_on = 2; wr_slp = 4;
        wr_en = 1; tick(); wr_en = 0; chk_pins("R12");
        tact = 0; tslot = 0; tick();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule